// File: doc/BRIEF.md
# I2C Master Clock and Edge Timing Generator

This block produces the SCL waveform and the SDA change points for an I2C master. A byte sequencer above it issues one command at a time: a START condition, a single data bit, or a STOP condition. The block runs the command on a time base that a power-of-two prescaler derives from the functional clock. Both lines are open-drain. The block only tells the pads when to pull a line low, and it reads SCL back so that a slave holding the clock low stretches the cycle.

Four 6-bit fields set the timing, each counted in prescaled ticks: the SCL low length, the SCL high length, the guard time around START and STOP, and the delay from the start of the low phase to the new SDA value. Every field and the prescaler select are captured when a START is accepted. Values changed during a transfer therefore apply from the next START. While the bus is owned, a START runs a repeated START. During each data-bit high phase a one-cycle strobe tells the sequencer when to capture SDA.

Top module: `i2c_scl_timing`

## Requirements
- R1: A data bit lasts (low+1) ticks with SCL pulled low, then (high+1) counted ticks with SCL released, then SCL is pulled low again. `done` pulses for one cycle and `busy` drops in that same cycle. Without stretching this totals 2^prescale × (low + high + 2) clocks from acceptance.
- R2: A tick is 2^prescale clocks, with prescale codes 0 to 7 giving divide by 1 to 128. The tick phase restarts at each accepted command, so the first tick lands 2^prescale clocks after the accepting edge.
- R3: In a data bit, SDA takes the value of `cmd_bit` (1 = released, 0 = pulled low) at low tick number min(dvalid, low), counted from 0. SDA does not change while SCL is released in a data bit.
- R4: In a data bit, `sample_stb` is high for exactly one cycle, on the edge that completes high tick number floor(high/2), counted from 0.
- R5: In a high or setup phase, a tick counts only if SCL reads back high. Ticks during which a slave holds SCL low lengthen the cycle, and the counted high time stays the same.
- R6: A START on a free bus pulls SDA low on the accepting edge. (sethold+1) ticks later it pulls SCL low and pulses `done`, and the bus is then owned.
- R7: A START while the bus is owned runs a repeated START. SDA is released at low tick min(dvalid, low). SCL is released after (low+1) ticks. After (sethold+1) counted high ticks SDA is pulled low, and after (sethold+1) more ticks SCL is pulled low and `done` pulses.
- R8: A STOP pulls SDA low at low tick min(dvalid, low) and releases SCL after (low+1) ticks. After (sethold+1) counted high ticks it releases SDA and pulses `done`, and the bus is then free.
- R9: The prescale select and the four timing fields are captured only when a START is accepted. Input changes at any other time have no effect until the next START.
- R10: These commands are ignored: any command while `busy` is high, a data bit or STOP while the bus is free, and the reserved code 2'b11. Command codes are 2'b00 data bit, 2'b01 START and 2'b10 STOP.
- R11: While `enable` is low, both lines are released, `busy`, `done` and `sample_stb` are low, any command in progress is dropped, and the bus is treated as free.
- R12: After reset both lines are released, `busy` is low and no pulse is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low releases the bus and clears all state |
| cfg_prescale | input | 3 | Tick divider select, divide by 2^value |
| cfg_low | input | 6 | SCL low length minus one, in ticks |
| cfg_high | input | 6 | SCL high length minus one, in ticks |
| cfg_sethold | input | 6 | START/STOP guard length minus one, in ticks |
| cfg_dvalid | input | 6 | Low tick index at which SDA changes |
| cmd_valid | input | 1 | Command request, taken when not busy |
| cmd_kind | input | 2 | 00 data bit, 01 START, 10 STOP, 11 reserved |
| cmd_bit | input | 1 | Bit to send; 1 releases SDA |
| scl_in | input | 1 | SCL level read back from the pad |
| busy | output | 1 | A command is running |
| done | output | 1 | One-cycle pulse when a command completes |
| sample_stb | output | 1 | One-cycle strobe in the middle of a data-bit high phase |
| scl_pull_low | output | 1 | Pull SCL low when high |
| sda_pull_low | output | 1 | Pull SDA low when high |

## Verification
The bench aims at the off-by-one edges of every counted phase. If a count runs one short, for example low-phase ticks or guard ticks taken as N rather than N+1, SCL or SDA moves one tick early at a compared cycle. It stretches SCL in the middle of a high phase and in the STOP setup phase: a design that keeps counting while the clock is held shortens the counted high time and ends early. It sets the data-valid delay beyond the low length and the high length to zero, so that a missing clamp leaves SDA unchanged and an end tick that misses the strobe is caught. It also changes the configuration inputs within a transfer, issues commands while busy and on a free bus, and drops enable after a START has taken the bus. A design that reloads its fields early, obeys stray commands or keeps driving a line after disable then shows a wrong level.

// File: rtl/sclgen_pkg.sv
// Shared encodings for the SCL timing generator.
// Assumes: command codes are fixed by the sequencer interface.
package sclgen_pkg;

    // Command codes presented on cmd_kind
    localparam logic [1:0] CMD_BIT   = 2'b00;
    localparam logic [1:0] CMD_START = 2'b01;
    localparam logic [1:0] CMD_STOP  = 2'b10;

    // Phase of the running command
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_SETUP,
        ST_HOLD
    } phase_e;

    // Kind of command once it has been accepted from the owned state
    typedef enum logic [1:0] {
        OP_BIT,
        OP_RSTART,
        OP_STOP
    } op_e;

endpackage

// File: rtl/sclgen_prescaler.sv
// Tick generator: fires one cycle in every 2^sel while run is high.
// Assumes: sel is stable while run is high; the count restarts from zero
// every time run rises, so tick phase is aligned to command acceptance.
module sclgen_prescaler #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             live_n,
    input  logic             run,
    input  logic [PRE_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << PRE_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Terminal count for the selected power-of-two divide
    always_comb begin
        limit = CNT_W'((1 << sel) - 1);
    end

    assign tick = run && (cnt_q == limit);

    // Count clocks between ticks, held at zero when not running
    always_ff @(posedge clk) begin
        if (!live_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: two ticks are never back to back unless the divide is one
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!live_n)
        (tick && sel != '0) |=> !tick);

endmodule

// File: rtl/sclgen_timing_hold.sv
// Timing field capture: stores prescale and phase lengths on load and
// derives the clamped data-valid index and the mid-high strobe index.
// Assumes: load is a single-cycle pulse from the phase controller.
module sclgen_timing_hold #(
    parameter int PRE_W = 3,
    parameter int FLD_W = 6
) (
    input  logic             clk,
    input  logic             live_n,
    input  logic             load,
    input  logic [PRE_W-1:0] pre_i,
    input  logic [FLD_W-1:0] low_i,
    input  logic [FLD_W-1:0] high_i,
    input  logic [FLD_W-1:0] guard_i,
    input  logic [FLD_W-1:0] dvalid_i,
    output logic [PRE_W-1:0] pre_q,
    output logic [FLD_W-1:0] low_q,
    output logic [FLD_W-1:0] high_q,
    output logic [FLD_W-1:0] guard_q,
    output logic [FLD_W-1:0] dv_idx,
    output logic [FLD_W-1:0] mid_idx
);
    logic [FLD_W-1:0] dvalid_q;

    // Capture all fields together when a START is taken
    always_ff @(posedge clk) begin
        if (!live_n) begin
            pre_q    <= '0;
            low_q    <= '0;
            high_q   <= '0;
            guard_q  <= '0;
            dvalid_q <= '0;
        end else if (load) begin
            pre_q    <= pre_i;
            low_q    <= low_i;
            high_q   <= high_i;
            guard_q  <= guard_i;
            dvalid_q <= dvalid_i;
        end
    end

    // Data change point may not pass the end of the low phase
    always_comb begin
        dv_idx  = (dvalid_q > low_q) ? low_q : dvalid_q;
        mid_idx = high_q >> 1;
    end

endmodule

// File: rtl/sclgen_phase_fsm.sv
// Phase controller: walks START, repeated START, data bit and STOP through
// low, high, setup and hold phases, one count per tick.
// Assumes: a START on a free bus finds SCL high; the bus is owned exactly
// when SCL is held low while idle.
module sclgen_phase_fsm
    import sclgen_pkg::*;
#(
    parameter int FLD_W = 6
) (
    input  logic             clk,
    input  logic             live_n,
    input  logic             tick,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_kind,
    input  logic             cmd_bit,
    input  logic             scl_in,
    input  logic [FLD_W-1:0] low_len,
    input  logic [FLD_W-1:0] high_len,
    input  logic [FLD_W-1:0] guard_len,
    input  logic [FLD_W-1:0] dv_idx,
    input  logic [FLD_W-1:0] mid_idx,
    output logic             start_load,
    output logic             busy,
    output logic             done,
    output logic             sample_stb,
    output logic             scl_low,
    output logic             sda_low
);
    phase_e           state_q;
    op_e              op_q;
    logic [FLD_W-1:0] cnt_q;
    logic             txb_q;
    logic             scl_low_q;
    logic             sda_low_q;
    logic             done_q;
    logic             stb_q;

    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign sample_stb = stb_q;
    assign scl_low    = scl_low_q;
    assign sda_low    = sda_low_q;

    // START accepted from idle: capture timing fields this edge
    assign start_load = (state_q == ST_IDLE) && cmd_valid && (cmd_kind == CMD_START);

    // Phase sequencing and line drive
    always_ff @(posedge clk) begin
        if (!live_n) begin
            state_q   <= ST_IDLE;
            op_q      <= OP_BIT;
            cnt_q     <= '0;
            txb_q     <= 1'b1;
            scl_low_q <= 1'b0;
            sda_low_q <= 1'b0;
            done_q    <= 1'b0;
            stb_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            stb_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        cnt_q <= '0;
                        txb_q <= cmd_bit;
                        case (cmd_kind)
                            CMD_START: begin
                                if (scl_low_q) begin
                                    op_q    <= OP_RSTART;
                                    state_q <= ST_LOW;
                                end else begin
                                    sda_low_q <= 1'b1;
                                    state_q   <= ST_HOLD;
                                end
                            end
                            CMD_BIT: begin
                                if (scl_low_q) begin
                                    op_q    <= OP_BIT;
                                    state_q <= ST_LOW;
                                end
                            end
                            CMD_STOP: begin
                                if (scl_low_q) begin
                                    op_q    <= OP_STOP;
                                    state_q <= ST_LOW;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        if (cnt_q == dv_idx) begin
                            sda_low_q <= (op_q == OP_BIT) ? ~txb_q : (op_q == OP_STOP);
                        end
                        if (cnt_q == low_len) begin
                            scl_low_q <= 1'b0;
                            cnt_q     <= '0;
                            state_q   <= (op_q == OP_BIT) ? ST_HIGH : ST_SETUP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_HIGH: begin
                    if (tick && scl_in) begin
                        if (cnt_q == mid_idx) begin
                            stb_q <= 1'b1;
                        end
                        if (cnt_q == high_len) begin
                            scl_low_q <= 1'b1;
                            done_q    <= 1'b1;
                            state_q   <= ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_SETUP: begin
                    if (tick && scl_in) begin
                        if (cnt_q == guard_len) begin
                            cnt_q <= '0;
                            if (op_q == OP_STOP) begin
                                sda_low_q <= 1'b0;
                                done_q    <= 1'b1;
                                state_q   <= ST_IDLE;
                            end else begin
                                sda_low_q <= 1'b1;
                                state_q   <= ST_HOLD;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (tick) begin
                        if (cnt_q == guard_len) begin
                            scl_low_q <= 1'b1;
                            done_q    <= 1'b1;
                            state_q   <= ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R3: data does not move while SCL is released in a data bit
    p_sda_steady_high_r3: assert property (@(posedge clk) disable iff (!live_n)
        (state_q == ST_HIGH && $past(state_q == ST_HIGH)) |-> $stable(sda_low_q));

    // R4: the capture strobe only follows a cycle with SCL released
    p_strobe_in_high_r4: assert property (@(posedge clk) disable iff (!live_n)
        stb_q |-> $past(!scl_low_q));

    // R5: a tick seen while SCL is held low does not advance the count
    p_stretch_freeze_r5: assert property (@(posedge clk) disable iff (!live_n)
        (state_q == ST_HIGH && tick && !scl_in) |=> (state_q == ST_HIGH && $stable(cnt_q)));

endmodule

// File: rtl/i2c_scl_timing.sv
// I2C master SCL and SDA edge timing generator, top level.
// Assumes: the sequencer presents one command at a time and waits for done;
// the pads implement open drain so a released line reads back high unless
// a slave holds it.
module i2c_scl_timing #(
    parameter int PRE_W = 3,
    parameter int FLD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PRE_W-1:0] cfg_prescale,
    input  logic [FLD_W-1:0] cfg_low,
    input  logic [FLD_W-1:0] cfg_high,
    input  logic [FLD_W-1:0] cfg_sethold,
    input  logic [FLD_W-1:0] cfg_dvalid,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_kind,
    input  logic             cmd_bit,
    input  logic             scl_in,
    output logic             busy,
    output logic             done,
    output logic             sample_stb,
    output logic             scl_pull_low,
    output logic             sda_pull_low
);
    logic             live_n;
    logic             tick;
    logic             start_load;
    logic [PRE_W-1:0] pre_q;
    logic [FLD_W-1:0] low_q;
    logic [FLD_W-1:0] high_q;
    logic [FLD_W-1:0] guard_q;
    logic [FLD_W-1:0] dv_idx;
    logic [FLD_W-1:0] mid_idx;

    // Disable acts as a synchronous clear on every register
    assign live_n = rst_n & enable;

    sclgen_timing_hold #(.PRE_W(PRE_W), .FLD_W(FLD_W)) u_hold (
        .clk      (clk),
        .live_n   (live_n),
        .load     (start_load),
        .pre_i    (cfg_prescale),
        .low_i    (cfg_low),
        .high_i   (cfg_high),
        .guard_i  (cfg_sethold),
        .dvalid_i (cfg_dvalid),
        .pre_q    (pre_q),
        .low_q    (low_q),
        .high_q   (high_q),
        .guard_q  (guard_q),
        .dv_idx   (dv_idx),
        .mid_idx  (mid_idx)
    );

    sclgen_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .live_n (live_n),
        .run    (busy),
        .sel    (pre_q),
        .tick   (tick)
    );

    sclgen_phase_fsm #(.FLD_W(FLD_W)) u_fsm (
        .clk        (clk),
        .live_n     (live_n),
        .tick       (tick),
        .cmd_valid  (cmd_valid),
        .cmd_kind   (cmd_kind),
        .cmd_bit    (cmd_bit),
        .scl_in     (scl_in),
        .low_len    (low_q),
        .high_len   (high_q),
        .guard_len  (guard_q),
        .dv_idx     (dv_idx),
        .mid_idx    (mid_idx),
        .start_load (start_load),
        .busy       (busy),
        .done       (done),
        .sample_stb (sample_stb),
        .scl_low    (scl_pull_low),
        .sda_low    (sda_pull_low)
    );

    // R1: completion is a single-cycle pulse
    p_done_single_r1: assert property (@(posedge clk) disable iff (!live_n)
        done |=> !done);

    // R9: captured timing does not move while a command runs
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!live_n)
        busy |=> ($stable(pre_q) && $stable(low_q) && $stable(high_q) && $stable(guard_q)));

    // R11: a disabled block leaves both lines released and is idle
    p_release_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_pull_low && !sda_pull_low && !busy));

endmodule

// File: tb/i2c_scl_timing_tb_top.sv
// Cycle-by-cycle reference bench for the SCL timing generator.
module i2c_scl_timing_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1;
    logic [2:0] cfg_prescale = '0;
    logic [5:0] cfg_low = '0;
    logic [5:0] cfg_high = '0;
    logic [5:0] cfg_sethold = '0;
    logic [5:0] cfg_dvalid = '0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_kind = 2'b00;
    logic       cmd_bit = 1'b1;
    logic       slave_hold = 1'b0;
    logic       scl_in;
    logic       busy, done, sample_stb, scl_pull_low, sda_pull_low;

    assign scl_in = !(scl_pull_low || slave_hold);

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_scl_timing dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .cfg_prescale (cfg_prescale),
        .cfg_low      (cfg_low),
        .cfg_high     (cfg_high),
        .cfg_sethold  (cfg_sethold),
        .cfg_dvalid   (cfg_dvalid),
        .cmd_valid    (cmd_valid),
        .cmd_kind     (cmd_kind),
        .cmd_bit      (cmd_bit),
        .scl_in       (scl_in),
        .busy         (busy),
        .done         (done),
        .sample_stb   (sample_stb),
        .scl_pull_low (scl_pull_low),
        .sda_pull_low (sda_pull_low)
    );

    // Reference model state
    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R12";
    logic  m_scl = 0, m_sda = 0, m_busy = 0, e_done = 0, e_stb = 0;
    int    mP = 1, mlo = 0, mhi = 0, msh = 0, mdv = 0;
    int    hold_left = 0;
    int    inj_cnt = 0;

    // Compare at this negedge, update bench-driven lines, advance one clock
    task automatic chk();
        vectors++;
        if (scl_pull_low !== m_scl || sda_pull_low !== m_sda || busy !== m_busy ||
            done !== e_done || sample_stb !== e_stb) begin
            miscompares++;
            $display("FAIL %s at %0t: scl,sda,busy,done,stb got %b%b%b%b%b expected %b%b%b%b%b",
                     cur_req, $time, scl_pull_low, sda_pull_low, busy, done, sample_stb,
                     m_scl, m_sda, m_busy, e_done, e_stb);
        end
        e_done = 0;
        e_stb  = 0;
        slave_hold = (hold_left > 0);
        if (hold_left > 0) hold_left--;
        cmd_valid = 1'b0;
        if (inj_cnt > 0) begin
            inj_cnt--;
            if (inj_cnt == 0) begin
                cmd_valid = 1'b1;
                cmd_kind  = 2'b10;
            end
        end
        @(negedge clk);
    endtask

    task automatic tick_wait();
        for (int k = 1; k < mP; k++) chk();
    endtask

    // Guard ticks ending with SCL pulled low (START and repeated START)
    task automatic hold_phase();
        for (int t = 0; t <= msh; t++) begin
            tick_wait();
            if (t == msh) begin
                m_scl = 1; m_busy = 0; e_done = 1;
            end
            chk();
        end
    endtask

    // Issue one command and follow its expected waveform to completion
    task automatic issue(input logic [1:0] kind, input logic b, input int stretch, input string req);
        int cnt;
        int dve;
        bit fin;
        cur_req   = req;
        cmd_valid = 1'b1;
        cmd_kind  = kind;
        cmd_bit   = b;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (kind == 2'b01) begin
            mP = 1 << cfg_prescale; mlo = cfg_low; mhi = cfg_high;
            msh = cfg_sethold; mdv = cfg_dvalid;
        end
        if (kind == 2'b01 && !m_scl) begin
            m_sda = 1; m_busy = 1;
            chk();
            hold_phase();
            return;
        end
        if (kind == 2'b11 || !m_scl) begin
            repeat (4) chk();
            return;
        end
        m_busy = 1;
        chk();
        dve = (mdv > mlo) ? mlo : mdv;
        for (int t = 0; t <= mlo; t++) begin
            tick_wait();
            if (t == dve) m_sda = (kind == 2'b00) ? !b : (kind == 2'b10);
            if (t == mlo) begin
                m_scl = 0; hold_left = stretch;
            end
            chk();
        end
        cnt = 0;
        fin = 0;
        while (!fin) begin
            tick_wait();
            if (!slave_hold) begin
                if (kind == 2'b00) begin
                    if (cnt == mhi / 2) e_stb = 1;
                    if (cnt == mhi) begin
                        m_scl = 1; m_busy = 0; e_done = 1; fin = 1;
                    end
                end else if (cnt == msh) begin
                    fin = 1;
                    if (kind == 2'b10) begin
                        m_sda = 0; m_busy = 0; e_done = 1;
                    end else begin
                        m_sda = 1;
                    end
                end
                cnt++;
            end
            chk();
        end
        if (kind == 2'b01) hold_phase();
    endtask

    task automatic set_cfg(input int p, input int lo, input int hi, input int sh, input int dv);
        cfg_prescale = 3'(p); cfg_low = 6'(lo); cfg_high = 6'(hi);
        cfg_sethold = 6'(sh); cfg_dvalid = 6'(dv);
    endtask

    // Watchdog: a hung run ends as a failure with the summary line
    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        cur_req = "R12";
        repeat (3) chk();

        // R10: data bit, STOP and the reserved code on a free bus are ignored
        set_cfg(0, 3, 2, 2, 1);
        issue(2'b00, 1'b0, 0, "R10");
        issue(2'b10, 1'b0, 0, "R10");
        issue(2'b11, 1'b0, 0, "R10");

        // R6, R1, R3, R4, R8 with divide by 1
        issue(2'b01, 1'b0, 0, "R6");
        issue(2'b00, 1'b1, 0, "R1");
        issue(2'b00, 1'b0, 0, "R3");
        issue(2'b10, 1'b0, 0, "R8");

        // R2: example timing, divide by 4, with stretching (R5) and repeated START (R7)
        set_cfg(2, 18, 6, 6, 3);
        issue(2'b01, 1'b0, 0, "R2");
        issue(2'b00, 1'b0, 0, "R2");
        issue(2'b00, 1'b1, 10, "R5");
        issue(2'b01, 1'b0, 7, "R7");
        issue(2'b00, 1'b1, 0, "R4");

        // R9: inputs changed mid-transfer only apply at the next START
        set_cfg(1, 2, 5, 1, 0);
        issue(2'b00, 1'b0, 0, "R9");
        issue(2'b01, 1'b0, 0, "R9");
        issue(2'b00, 1'b1, 0, "R9");

        // R3: data-valid index beyond the low length is clamped; R4 with high of zero
        set_cfg(1, 2, 0, 1, 5);
        issue(2'b01, 1'b0, 0, "R3");
        issue(2'b00, 1'b0, 0, "R3");
        issue(2'b00, 1'b1, 0, "R4");

        // R10: a STOP request while busy is ignored
        inj_cnt = 3;
        issue(2'b00, 1'b0, 0, "R10");
        cur_req = "R10";
        repeat (6) chk();

        // R5: stretch during STOP setup
        issue(2'b10, 1'b0, 9, "R5");

        // R2: largest divide
        set_cfg(7, 0, 0, 0, 0);
        issue(2'b01, 1'b0, 0, "R2");
        issue(2'b00, 1'b0, 0, "R2");
        issue(2'b10, 1'b0, 0, "R2");

        // R11: disable while a data bit runs on an owned bus
        set_cfg(2, 4, 4, 2, 1);
        issue(2'b01, 1'b0, 0, "R11");
        cur_req   = "R11";
        cmd_valid = 1'b1;
        cmd_kind  = 2'b00;
        cmd_bit   = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        m_busy = 1;
        chk();
        enable = 1'b0;
        chk();
        m_scl = 0; m_sda = 0; m_busy = 0;
        chk();
        enable = 1'b1;
        chk();
        // R11: bus is free afterwards so a data bit is ignored
        issue(2'b00, 1'b0, 0, "R11");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule